// File: doc/BRIEF.md
# Interrupt Pending/Mask and Mode Register Controller

This block is a small memory-mapped register file that sits between six peripheral interrupt sources and one processor interrupt line. Each source can raise or drop its own bit in a pending register through strobe inputs. A six-bit mask register selects which pending bits may reach the processor. The interrupt output is a registered signal that is high whenever some pending bit is also enabled in the mask.

The block also holds a mode register and a read-only version word. The mode register has a 7-bit length field and three stored mode flags. Software never writes mask or mode flags as plain values. Each flag has its own clear command bit and its own set command bit in the written word. When both are 1, the clear acts first and the set acts second, so the flag ends up set. One command bit in the mode word does not touch the mode register at all. Instead it acknowledges the sixth source and drops that source's pending bit.

The bus port is a plain single-cycle register interface. A write takes effect at the clock edge where `bus_wr` is high. `bus_wdata` is ANDed with `bus_wmask` before any bit is interpreted. Read data is combinational from `bus_addr`. The port has no handshake, so it never applies back-pressure and every access completes at once.

Top module: `intr_mode_ctrl`

## Requirements
- R1: After reset, word address 1 (version) reads 0x02020102. Address 0 (mode), address 2 (pending, bits 5:0) and address 3 (mask, bits 5:0) read 0, and `irq_o` is 0.
- R2: Before a written word is interpreted, every data bit whose `bus_wmask` bit is 0 is treated as 0.
- R3: Every write to address 0 loads mode bits 6:0 from command bits 6:0.
- R4: In a mode write, command bits 7 and 8 clear and set mode bit 7. Bits 9 and 10 clear and set mode bit 8. Bits 12 and 13 clear and set mode bit 9. Command bits with value 0 leave the matching flag unchanged.
- R5: In a mode write, command bit 11 clears pending bit 5 and leaves every stored mode bit unchanged.
- R6: In a write to address 3, command bit 2n clears mask bit n and command bit 2n+1 sets it, for n = 0..5.
- R7: When the clear and set command bits of one flag (mode or mask) are both 1, the flag ends up set.
- R8: A high `src_raise[n]` sets pending bit n. A high `src_clear[n]` clears pending bit n only. All other pending bits keep their values.
- R9: If a raise for source n meets a clear of bit n in the same cycle, the raise wins. The clear may come from `src_clear` or from the mode acknowledge bit. The pending bit ends up set.
- R10: `irq_o` equals, one cycle later, the OR of (pending AND mask) as it stood in the previous cycle.
- R11: Writes to addresses 1 and 2 change nothing. Reads of addresses above 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write enable, ANDed with the write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_raise | input | 6 | Per-source raise strobes |
| src_clear | input | 6 | Per-source clear strobes |
| irq_o | output | 1 | Registered processor interrupt request |

## Verification
Two functions can touch the same pending bit in one cycle: a source raise, and either a peripheral clear strobe or the acknowledge bit in a mode write. The bench provokes this in two ways. It sweeps every raise/clear pattern on all six sources together. It also drives source 5's raise during mode writes that carry the acknowledge bit. A second same-cycle case is a clear command and a set command for one flag in a single word. The full mask and mode command sweeps cover every such pair. In each cycle the bench compares the read-back registers and the one-cycle-delayed `irq_o` with a model built from the requirements. That model applies clear before set, and raise last.

// File: rtl/intr_mode_pkg.sv
package intr_mode_pkg;
  localparam int unsigned NUM_SRC   = 6;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned LEN_W     = 7;
  localparam int unsigned NUM_FLAGS = 3;

  // Command bit positions inside a mode-register write
  localparam int unsigned CMD_INIT_CLR = 7;
  localparam int unsigned CMD_INIT_SET = 8;
  localparam int unsigned CMD_TEST_CLR = 9;
  localparam int unsigned CMD_TEST_SET = 10;
  localparam int unsigned CMD_ACK_SRC  = 11;
  localparam int unsigned CMD_REGM_CLR = 12;
  localparam int unsigned CMD_REGM_SET = 13;

  localparam int unsigned ACK_SRC_IDX = 5;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_VER  = 2'd1,
    SEL_PEND = 2'd2,
    SEL_MASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/setclr_bank.sv
module setclr_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] clr_cmd,
  input  logic [N-1:0] set_cmd,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (en) begin
        if (set_cmd[i])      bit_q <= 1'b1;
        else if (clr_cmd[i]) bit_q <= 1'b0;
      end
    end
    assign q[i] = bit_q;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && set_cmd[i]) |=> q[i]);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || (!set_cmd[i] && !clr_cmd[i])) |=> $stable(q[i]));
  end
endmodule

// File: rtl/pending_bank.sv
module pending_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raise,
  input  logic [N-1:0] clear,
  output logic [N-1:0] q
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)        pend_q[i] <= 1'b0;
      else if (raise[i]) pend_q[i] <= 1'b1;
      else if (clear[i]) pend_q[i] <= 1'b0;
    end

    // R9
    raise_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      raise[i] |=> q[i]);

    // R8
    clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear[i] && !raise[i]) |=> !q[i]);

    // R8
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear[i] && !raise[i]) |=> $stable(q[i]));
  end

  assign q = pend_q;
endmodule

// File: rtl/mode_reg.sv
module mode_reg
  import intr_mode_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] cmd,
  output logic [W-1:0] mode_word,
  output logic         ack_src
);
  logic [LEN_W-1:0]     len_q;
  logic [NUM_FLAGS-1:0] flags_q;
  logic [NUM_FLAGS-1:0] f_clr;
  logic [NUM_FLAGS-1:0] f_set;

  always_ff @(posedge clk) begin
    if (!rst_n)     len_q <= '0;
    else if (wr_en) len_q <= cmd[LEN_W-1:0];
  end

  assign f_clr = {cmd[CMD_REGM_CLR], cmd[CMD_TEST_CLR], cmd[CMD_INIT_CLR]};
  assign f_set = {cmd[CMD_REGM_SET], cmd[CMD_TEST_SET], cmd[CMD_INIT_SET]};

  setclr_bank #(.N(NUM_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (wr_en),
    .clr_cmd(f_clr),
    .set_cmd(f_set),
    .q      (flags_q)
  );

  assign mode_word = {{(W-LEN_W-NUM_FLAGS){1'b0}}, flags_q, len_q};
  assign ack_src   = wr_en & cmd[CMD_ACK_SRC];

  // R3
  len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> len_q == $past(cmd[LEN_W-1:0]));

  // R5
  ack_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd[CMD_ACK_SRC] && f_clr == '0 && f_set == '0) |=> $stable(flags_q));
endmodule

// File: rtl/intr_mode_ctrl.sv
module intr_mode_ctrl
  import intr_mode_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter logic [31:0] VERSION = 32'h0202_0102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_wmask,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_SRC-1:0] src_raise,
  input  logic [NUM_SRC-1:0] src_clear,
  output logic              irq_o
);
  localparam int unsigned SEL_W = 2;

  logic [DATA_W-1:0]  cmd;
  logic               in_map;
  reg_sel_e           sel;
  logic               wr_mode;
  logic               wr_mask;
  logic [DATA_W-1:0]  mode_word;
  logic               ack_src;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_clr;
  logic [NUM_SRC-1:0] mask_set;
  logic [NUM_SRC-1:0] pend_clr;
  logic               irq_q;

  assign cmd    = bus_wdata & bus_wmask;
  assign in_map = (bus_addr >> SEL_W) == '0;
  assign sel    = reg_sel_e'(bus_addr[SEL_W-1:0]);

  assign wr_mode = bus_wr && in_map && (sel == SEL_MODE);
  assign wr_mask = bus_wr && in_map && (sel == SEL_MASK);

  mode_reg #(.W(DATA_W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_mode),
    .cmd      (cmd),
    .mode_word(mode_word),
    .ack_src  (ack_src)
  );

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_mask_cmd
    assign mask_clr[n] = cmd[2*n];
    assign mask_set[n] = cmd[2*n+1];
  end

  setclr_bank #(.N(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (wr_mask),
    .clr_cmd(mask_clr),
    .set_cmd(mask_set),
    .q      (mask_q)
  );

  assign pend_clr = src_clear | (NUM_SRC'(ack_src) << ACK_SRC_IDX);

  pending_bank #(.N(NUM_SRC)) u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .raise(src_raise),
    .clear(pend_clr),
    .q    (pend_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(pend_q & mask_q);
  end
  assign irq_o = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      unique case (sel)
        SEL_MODE: bus_rdata = mode_word;
        SEL_VER:  bus_rdata = VERSION;
        SEL_PEND: bus_rdata = {{(DATA_W-NUM_SRC){1'b0}}, pend_q};
        SEL_MASK: bus_rdata = {{(DATA_W-NUM_SRC){1'b0}}, mask_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R10
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|(pend_q & mask_q)));

  // R11
  pend_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && in_map && sel == SEL_PEND && src_raise == '0 && src_clear == '0)
      |=> $stable(pend_q));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
endmodule

// File: tb/intr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module intr_mode_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_wmask = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  src_raise = '0;
  logic [5:0]  src_clear = '0;
  logic        irq_o;

  int checks = 0;
  int failures = 0;

  logic [9:0] mode_m = '0;
  logic [5:0] mask_m = '0;
  logic [5:0] pend_m = '0;
  logic       irq_m  = 1'b0;

  always #2.5 clk = ~clk;

  intr_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
    .src_raise(src_raise), .src_clear(src_clear), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit wr, input logic [3:0] a, input logic [31:0] d,
                      input logic [31:0] wm, input logic [5:0] rs, input logic [5:0] cl);
    logic [31:0] c;
    logic        ack;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; bus_wmask = wm;
    src_raise = rs; src_clear = cl;
    @(posedge clk);
    c     = d & wm;
    irq_m = |(pend_m & mask_m);
    ack   = wr && a == 4'd0 && c[11];
    pend_m = (pend_m & ~(cl | {ack, 5'b0})) | rs;
    if (wr && a == 4'd0) begin
      mode_m[6:0] = c[6:0];
      if (c[7])  mode_m[7] = 1'b0;
      if (c[8])  mode_m[7] = 1'b1;
      if (c[9])  mode_m[8] = 1'b0;
      if (c[10]) mode_m[8] = 1'b1;
      if (c[12]) mode_m[9] = 1'b0;
      if (c[13]) mode_m[9] = 1'b1;
    end
    if (wr && a == 4'd3) begin
      for (int n = 0; n < 6; n++) begin
        if (c[2*n])   mask_m[n] = 1'b0;
        if (c[2*n+1]) mask_m[n] = 1'b1;
      end
    end
    @(negedge clk);
    bus_wr = 1'b0; src_raise = '0; src_clear = '0;
    check("R10 irq", {31'b0, irq_o}, {31'b0, irq_m});
  endtask

  task automatic read_chk(input logic [3:0] a, input string tag, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    read_chk(4'd1, "R1 version", 32'h0202_0102);
    read_chk(4'd0, "R1 mode", 32'h0);
    read_chk(4'd2, "R1 pend", 32'h0);
    read_chk(4'd3, "R1 mask", 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // R6 R7: full sweep of mask command words, full enable
    for (int v = 0; v < 4096; v++) begin
      step(1'b1, 4'd3, 32'(v), 32'hFFFF_FFFF, 6'h0, 6'h0);
      read_chk(4'd3, "R6 R7 mask", {26'b0, mask_m});
    end
    // R2: mask sweep with partial write enables
    for (int v = 0; v < 1024; v++) begin
      step(1'b1, 4'd3, $urandom(), $urandom(), 6'h0, 6'h0);
      read_chk(4'd3, "R2 mask wmask", {26'b0, mask_m});
    end

    // R8 R9: every raise/clear combination on all sources
    for (int v = 0; v < 4096; v++) begin
      step(1'b0, 4'd0, 32'h0, 32'h0, v[5:0], v[11:6]);
      read_chk(4'd2, "R8 R9 pend", {26'b0, pend_m});
    end

    // R3 R4 R5 R9: full sweep of mode command bits 13:0, raise 5 alongside ack
    for (int v = 0; v < 16384; v++) begin
      step(1'b1, 4'd0, 32'(v), 32'hFFFF_FFFF, v[1] ? 6'h20 : 6'h0, 6'h0);
      read_chk(4'd0, "R3 R4 R7 mode", {22'b0, mode_m});
      read_chk(4'd2, "R5 R9 ack", {26'b0, pend_m});
      if (v[0] == 1'b0) step(1'b0, 4'd0, 32'h0, 32'h0, 6'h20, 6'h0);
    end
    // R2: mode writes with partial enables
    for (int v = 0; v < 1024; v++) begin
      step(1'b1, 4'd0, $urandom(), $urandom(), 6'h0, 6'h0);
      read_chk(4'd0, "R2 mode wmask", {22'b0, mode_m});
    end

    // R11: writes to version and pending are ignored; reads above 3 are zero
    step(1'b0, 4'd0, 32'h0, 32'h0, 6'h15, 6'h0);
    step(1'b1, 4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h0, 6'h0);
    read_chk(4'd2, "R11 pend write", {26'b0, pend_m});
    step(1'b1, 4'd1, 32'h0, 32'hFFFF_FFFF, 6'h0, 6'h0);
    read_chk(4'd1, "R11 version write", 32'h0202_0102);
    for (int a = 4; a < 16; a++) begin
      step(1'b1, 4'(a), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h0, 6'h0);
      read_chk(4'(a), "R11 unmapped", 32'h0);
      read_chk(4'd0, "R11 mode kept", {22'b0, mode_m});
      read_chk(4'd3, "R11 mask kept", {26'b0, mask_m});
    end

    // R10: irq follows pending AND mask, per source
    for (int n = 0; n < 6; n++) begin
      step(1'b0, 4'd0, 32'h0, 32'h0, 6'h0, 6'h3F);
      step(1'b1, 4'd3, 32'h555, 32'hFFFF_FFFF, 6'h0, 6'h0);
      step(1'b1, 4'd3, 32'(1) << (2*n+1), 32'hFFFF_FFFF, 6'(1) << n, 6'h0);
      step(1'b0, 4'd0, 32'h0, 32'h0, 6'h0, 6'h0);
      step(1'b0, 4'd0, 32'h0, 32'h0, 6'h0, 6'(1) << n);
      step(1'b0, 4'd0, 32'h0, 32'h0, 6'h0, 6'h0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule